// File: doc/BRIEF.md
# Prescaled Up/Down Interval Timer

This block is an interval timer driven by the system clock through a power-of-two prescaler. Software programs a start value, an end value and a control word through a small register write port. It then sets the run bit. On the first counting strobe after the run bit is set, the counter takes the start value. On each later strobe it steps up or down by one. Whenever the counter equals the end value on a strobe, the programmed end-of-period action applies: reload the start value, stop the timer, or keep counting with modulo wrap.

A strobe that finds a match can also raise a one-cycle trigger pulse, for example to launch a converter sample. The live counter value, the run state and a sticky lock-violation flag are visible on plain output pins. Configuration is locked while the timer runs. A write to any locked field is dropped and raises the flag. Only the run bit may change while the timer runs.

The write port is a valid/ready stream. `wr_ready` is held high permanently, so the port never applies back-pressure. Every beat with `wr_valid` high is consumed on that clock edge.

Top module: `ivtimer`

## Requirements
- R1: After reset `cnt_o` is 0, `trig_o`, `running_o` and `err_o` are 0, and every register is 0.
- R2: `wr_ready` is always 1, and a beat with `wr_valid` high is taken on that edge. Address map: 0 = control, 1 = start value, 2 = end value. A write to address 3 has no effect and does not set `err_o`. Control word layout: bit0 run, bit1 down (1 = count down), bits3:2 action (00 reload, 01 stop, 10 continue, 11 stop), bit4 trigger enable, bits10:5 prescale exponent N.
- R3: While running, a count strobe occurs every 2^N system clocks. N below 2 acts as 2 and N above 33 acts as 33. The divider restarts from zero at start, so the first strobe falls on the 2^N-th edge after the edge that sets the run bit.
- R4: The first strobe after start loads the start value into the counter and does not step it.
- R5: Each later strobe with no match adds 1 to the counter (up) or subtracts 1 (down), modulo 2^16. Between strobes the counter holds its value.
- R6: In reload mode, a strobe that finds the counter equal to the end value reloads the start value. Up-counting from 0 to 9 therefore takes 10 strobes.
- R7: In stop mode (action 01 or 11), a matching strobe clears the run bit on that edge and the counter keeps the end value.
- R8: In continue mode, a matching strobe steps the counter as usual, wrapping modulo 2^16.
- R9: `trig_o` is high for exactly one system clock: the cycle whose closing edge is a matching strobe. It is raised only when trigger enable is set.
- R10: While running, writes to start, end, or any control field other than run are ignored and set `err_o`, which stays set until reset. A control write whose non-run fields equal the stored ones is accepted and sets no error.
- R11: Clearing the run bit stops the counter at the next edge, and the counter value stays on `cnt_o`. A later start loads the start value on its first strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Register write beat valid |
| wr_ready | output | 1 | Always 1; the port never stalls |
| wr_addr | input | 2 | Register select |
| wr_data | input | CW | Write data |
| cnt_o | output | CW | Live counter value |
| trig_o | output | 1 | One-cycle end-of-period trigger |
| running_o | output | 1 | Stored run bit |
| err_o | output | 1 | Sticky flag for a write while locked |

## Verification
Some behaviours are checked by assertions on every cycle:
- The counter moves only on a strobe.
- The first strobe loads the start value.
- An up step with no match adds exactly one.
- A stop-mode match drops the run bit.
- The trigger is a single cycle and only occurs while running.
- The lock flag is sticky, and a locked start write raises it.

The bench scenarios cover the rest:
- The exact strobe period for each prescale exponent, including clamped exponents.
- Whole value sequences for reload, stop and continue in both directions, across the 16-bit wrap.
- Trigger timing against the match.
- That dropped writes leave the counting sequence unchanged.
- Freeze on disable and reload on restart.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
  localparam int CTL_W = 11;
  localparam int PSEL_W = 6;

  localparam logic [1:0] A_CTRL  = 2'd0;
  localparam logic [1:0] A_START = 2'd1;
  localparam logic [1:0] A_END   = 2'd2;

  typedef enum logic [1:0] {
    ACT_RELOAD = 2'd0,
    ACT_STOP   = 2'd1,
    ACT_CONT   = 2'd2,
    ACT_HALT   = 2'd3
  } act_e;

  // packed from MSB to LSB: psel, trg, act, down, run
  typedef struct packed {
    logic [PSEL_W-1:0] psel;
    logic              trg;
    act_e              act;
    logic              down;
    logic              run;
  } ctrl_t;
endpackage

// File: rtl/ivt_regs.sv
module ivt_regs
  import ivt_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  input  logic [1:0]    wr_addr,
  input  logic [CW-1:0] wr_data,
  input  logic          stop_req,
  output ctrl_t         cfg,
  output logic [CW-1:0] start_q,
  output logic [CW-1:0] end_q,
  output logic          err_q
);
  ctrl_t wr_ctl;
  logic  fields_differ;

  assign wr_ctl = ctrl_t'(wr_data[CTL_W-1:0]);
  assign fields_differ = {wr_ctl.psel, wr_ctl.trg, wr_ctl.act, wr_ctl.down}
                      != {cfg.psel, cfg.trg, cfg.act, cfg.down};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg     <= '0;
      start_q <= '0;
      end_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      if (wr_valid) begin
        case (wr_addr)
          A_CTRL: begin
            if (!cfg.run) begin
              cfg <= wr_ctl;
            end else begin
              cfg.run <= wr_ctl.run;
              if (fields_differ) err_q <= 1'b1;
            end
          end
          A_START: begin
            if (!cfg.run) start_q <= wr_data;
            else          err_q   <= 1'b1;
          end
          A_END: begin
            if (!cfg.run) end_q <= wr_data;
            else          err_q <= 1'b1;
          end
          default: ;
        endcase
      end
      // an end-of-period stop wins over a same-cycle run write
      if (stop_req) cfg.run <= 1'b0;
    end
  end
endmodule

// File: rtl/ivt_prescaler.sv
module ivt_prescaler
  import ivt_pkg::*;
#(
  parameter int NMIN = 2,
  parameter int NMAX = 33
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [PSEL_W-1:0] psel,
  output logic              stb
);
  localparam int DIVW = NMAX + 1;

  logic [DIVW-1:0]   div_q;
  logic [DIVW-1:0]   mask;
  logic [PSEL_W-1:0] n_eff;

  always_comb begin
    if (psel < PSEL_W'(NMIN))      n_eff = PSEL_W'(NMIN);
    else if (psel > PSEL_W'(NMAX)) n_eff = PSEL_W'(NMAX);
    else                           n_eff = psel;
  end

  for (genvar i = 0; i < DIVW; i++) begin : g_mask
    assign mask[i] = (PSEL_W'(i) < n_eff);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)   div_q <= '0;
    else if (en)  div_q <= div_q + DIVW'(1);
    else          div_q <= '0;
  end

  assign stb = en && ((div_q & mask) == mask);
endmodule

// File: rtl/ivt_counter.sv
module ivt_counter
  import ivt_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          stb,
  input  logic [CW-1:0] start_v,
  input  logic [CW-1:0] end_v,
  input  logic          down,
  input  act_e          act,
  output logic [CW-1:0] cnt_q,
  output logic          loaded_q,
  output logic          hit,
  output logic          stop_req
);
  logic          match;
  logic [CW-1:0] step_v;

  assign match    = (cnt_q == end_v);
  assign hit      = stb && loaded_q && match;
  assign stop_req = hit && ((act == ACT_STOP) || (act == ACT_HALT));
  assign step_v   = down ? cnt_q - CW'(1) : cnt_q + CW'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      loaded_q <= 1'b0;
    end else if (!en) begin
      loaded_q <= 1'b0;
    end else if (stb) begin
      loaded_q <= 1'b1;
      if (!loaded_q) begin
        cnt_q <= start_v;
      end else if (match) begin
        case (act)
          ACT_RELOAD: cnt_q <= start_v;
          ACT_CONT:   cnt_q <= step_v;
          default:    ;
        endcase
      end else begin
        cnt_q <= step_v;
      end
    end
  end
endmodule

// File: rtl/ivtimer.sv
module ivtimer
  import ivt_pkg::*;
#(
  parameter int CW   = 16,
  parameter int NMIN = 2,
  parameter int NMAX = 33
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [1:0]    wr_addr,
  input  logic [CW-1:0] wr_data,
  output logic [CW-1:0] cnt_o,
  output logic          trig_o,
  output logic          running_o,
  output logic          err_o
);
  ctrl_t         cfg;
  logic [CW-1:0] start_q;
  logic [CW-1:0] end_q;
  logic          cnt_stb;
  logic          loaded;
  logic          hit;
  logic          stop_req;

  assign wr_ready = 1'b1;

  ivt_regs #(.CW(CW)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_valid (wr_valid),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .stop_req (stop_req),
    .cfg      (cfg),
    .start_q  (start_q),
    .end_q    (end_q),
    .err_q    (err_o)
  );

  ivt_prescaler #(.NMIN(NMIN), .NMAX(NMAX)) u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (cfg.run),
    .psel  (cfg.psel),
    .stb   (cnt_stb)
  );

  ivt_counter #(.CW(CW)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (cfg.run),
    .stb      (cnt_stb),
    .start_v  (start_q),
    .end_v    (end_q),
    .down     (cfg.down),
    .act      (cfg.act),
    .cnt_q    (cnt_o),
    .loaded_q (loaded),
    .hit      (hit),
    .stop_req (stop_req)
  );

  assign trig_o    = hit && cfg.trg;
  assign running_o = cfg.run;
endmodule

// File: rtl/ivtimer_chk.sv
module ivtimer_chk
  import ivt_pkg::*;
#(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_valid,
  input logic [1:0]    wr_addr,
  input logic [CW-1:0] cnt_o,
  input logic          trig_o,
  input logic          running_o,
  input logic          err_o,
  input logic          stb,
  input logic          loaded,
  input logic [CW-1:0] start_q,
  input logic [CW-1:0] end_q,
  input logic          down,
  input logic [1:0]    act
);
  // R5: the counter only moves on a strobe
  p_hold_between_strobes_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !stb |=> $stable(cnt_o));

  // R4: the first strobe loads the start value
  p_first_strobe_loads_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && !loaded) |=> (cnt_o == $past(start_q)));

  // R5: an up step with no match adds one
  p_up_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && loaded && !down && (cnt_o != end_q)) |=> (cnt_o == CW'($past(cnt_o) + CW'(1))));

  // R7: a stop-mode match clears the run bit and holds the count
  p_stop_on_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && loaded && (cnt_o == end_q) && ((act == ACT_STOP) || (act == ACT_HALT)))
      |=> (!running_o && $stable(cnt_o)));

  // R9: the trigger only occurs while running and lasts one cycle
  p_trig_running_r9: assert property (@(posedge clk) disable iff (!rst_n)
    trig_o |-> running_o);
  p_trig_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    trig_o |=> !trig_o);

  // R10: a locked start write raises the flag, and the flag is sticky
  p_locked_start_err_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && running_o && (wr_addr == A_START)) |=> err_o);
  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> err_o);
endmodule

bind ivtimer ivtimer_chk #(.CW(CW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_valid  (wr_valid),
  .wr_addr   (wr_addr),
  .cnt_o     (cnt_o),
  .trig_o    (trig_o),
  .running_o (running_o),
  .err_o     (err_o),
  .stb       (cnt_stb),
  .loaded    (loaded),
  .start_q   (start_q),
  .end_q     (end_q),
  .down      (cfg.down),
  .act       (cfg.act)
);

// File: tb/ivtimer_tb_top.sv
module ivtimer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_valid = 1'b0;
  logic [1:0]    wr_addr = '0;
  logic [CW-1:0] wr_data = '0;
  logic          wr_ready;
  logic [CW-1:0] cnt_o;
  logic          trig_o;
  logic          running_o;
  logic          err_o;

  int checks = 0;
  int errors = 0;
  int prev   = 0;

  ivtimer dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_valid  (wr_valid),
    .wr_ready  (wr_ready),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .cnt_o     (cnt_o),
    .trig_o    (trig_o),
    .running_o (running_o),
    .err_o     (err_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input longint actual, input longint expected);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, actual, expected, $time);
    end
  endtask

  function automatic logic [15:0] mk(input bit run, input bit down, input int act,
                                     input bit trg, input int n);
    logic [15:0] w;
    w = '0;
    w[0]    = run;
    w[1]    = down;
    w[3:2]  = act[1:0];
    w[4]    = trg;
    w[10:5] = n[5:0];
    return w;
  endfunction

  // expected counter value after k strobes since start
  function automatic int exp_cnt(input longint k, input int s, input int e, input bit down,
                                 input int act, input int pv);
    longint i, len, off;
    if (k == 0) return pv;
    i   = k - 1;
    len = down ? (((s - e) & 16'hFFFF) + 1) : (((e - s) & 16'hFFFF) + 1);
    if (act == 0)      off = i % len;
    else if (act == 2) off = i & 16'hFFFF;
    else               off = (i < len) ? i : len - 1;
    return down ? int'((s - off) & 16'hFFFF) : int'((s + off) & 16'hFFFF);
  endfunction

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_valid = 1'b1;
    wr_addr  = a;
    wr_data  = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    prev = 0;
  endtask

  // kind: 0 none, 1 start write, 2 direction change, 3 run off, 4 end write, 5 address 3
  task automatic run(input bit rst, input string req, input int n, input int s, input int e,
                     input bit down, input int act, input bit trg, input int cycles,
                     input int kind, input int dt);
    int     neff, ev;
    longint p, len, tend, tc, k;
    bit     errkind, etrig;
    if (rst) do_reset();
    wr(2'd0, mk(0, down, act, trg, n));
    wr(2'd1, 16'(s));
    wr(2'd2, 16'(e));
    wr(2'd0, mk(1, down, act, trg, n));
    neff    = (n < 2) ? 2 : ((n > 33) ? 33 : n);
    p       = longint'(1) << neff;
    len     = down ? (((s - e) & 16'hFFFF) + 1) : (((e - s) & 16'hFFFF) + 1);
    tend    = (act == 1 || act == 3) ? (len + 1) * p : 64'd1 << 40;
    if (kind == 3 && (dt + 1) < tend) tend = dt + 1;
    errkind = (kind == 1) || (kind == 2) || (kind == 4);
    ev      = prev;
    for (int t = 0; t < cycles; t++) begin
      tc = (t < tend) ? t : tend;
      k  = tc / p;
      ev = exp_cnt(k, s, e, down, act, prev);
      chk(cnt_o == 16'(ev), (k == 1) ? "R4" : req, cnt_o, ev);
      chk(running_o == (t < tend), "R7 run state", running_o, (t < tend));
      etrig = trg && (t < tend) && ((t % p) == p - 1) && (k >= 1) && (ev == e);
      chk(trig_o == etrig, "R9 trigger", trig_o, etrig);
      chk(err_o == (errkind && t > dt), "R10 lock flag", err_o, (errkind && t > dt));
      if (kind != 0 && t == dt) begin
        wr_valid = 1'b1;
        case (kind)
          1: begin wr_addr = 2'd1; wr_data = 16'h1234; end
          2: begin wr_addr = 2'd0; wr_data = mk(1, !down, act, trg, n); end
          3: begin wr_addr = 2'd0; wr_data = mk(0, down, act, trg, n); end
          4: begin wr_addr = 2'd2; wr_data = 16'h0003; end
          default: begin wr_addr = 2'd3; wr_data = 16'hFFFF; end
        endcase
      end else begin
        wr_valid = 1'b0;
      end
      @(negedge clk);
    end
    wr_valid = 1'b0;
    prev = ev;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state, R2 no back-pressure
    chk(cnt_o == 0, "R1 counter", cnt_o, 0);
    chk(trig_o == 0, "R1 trigger", trig_o, 0);
    chk(running_o == 0, "R1 run", running_o, 0);
    chk(err_o == 0, "R1 flag", err_o, 0);
    chk(wr_ready == 1, "R2 ready", wr_ready, 1);
    // R6 up reload 0..9 with trigger; R2 address 3 ignored
    run(1, "R6", 2, 0, 9, 0, 0, 1, 90, 5, 13);
    chk(wr_ready == 1, "R2 ready after traffic", wr_ready, 1);
    // R5 down reload, trigger disabled
    run(1, "R5", 3, 20, 14, 1, 0, 0, 160, 0, 0);
    // R7 stop mode up, and action 11 down with clamped exponent (R3)
    run(1, "R7", 2, 5, 8, 0, 1, 1, 40, 0, 0);
    run(1, "R3", 1, 3, 0, 1, 3, 1, 40, 0, 0);
    // R8 continue across the 16-bit wrap
    run(1, "R8", 2, 16'hFFFD, 16'hFFFE, 0, 2, 1, 48, 0, 0);
    // R3 exponent 5, then R11 run cleared at cycle 150 and frozen
    run(1, "R11", 5, 7, 9, 0, 0, 1, 200, 3, 150);
    // R11 restart without reset: holds frozen value, then loads start
    run(0, "R11", 2, 100, 102, 0, 0, 1, 40, 0, 0);
    // R3 exponent above 33 clamps: nothing loads for a long while
    run(1, "R3", 40, 55, 60, 0, 0, 1, 30, 0, 0);
    // R10 locked writes: start, direction, end
    run(1, "R10", 2, 0, 5, 0, 0, 1, 60, 1, 9);
    run(1, "R10", 2, 30, 26, 1, 0, 1, 60, 2, 6);
    run(1, "R10", 2, 2, 7, 0, 0, 1, 60, 4, 20);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule